// File: doc/BRIEF.md
# Write Buffer With Read Bypass

This block sits between a cache and a slower memory. The cache hands it every write (a write-through store, or a dirty line evicted by a write-back cache) as an address/data pair. The pairs wait in a small first-in first-out queue, and one memory request port sends them out, oldest first, whenever memory accepts a request.

A read miss also enters here before it reaches memory. Its address is compared with every pending entry at once. If no entry matches, the read is placed on the memory port ahead of all queued writes, so it does not wait for the queue to empty. If entries match, the data of the most recently queued matching entry goes straight back to the reader and memory sees no read. With this rule an evicted dirty line can be queued first, the missing line read next, and the eviction written after it.

The queue depth must be a power of two, at least 2. One read is handled at a time.

Top module: `wbuf_bypass`

## Requirements
- R1: After reset, `fill_level` is 0, `wr_ready` and `rd_ready` are 1, and `mem_req_valid` and `rd_resp_valid` are 0.
- R2: A write is taken on a clock edge where `wr_valid` and `wr_ready` are both 1, and `fill_level` is one higher after that edge. The queue holds up to 4 entries.
- R3: When `fill_level` equals 4, `wr_ready` is 0, and a write offered then is dropped: the count stays at 4 and that pair never reaches the memory port.
- R4: With no read waiting to be sent, the memory port shows the oldest entry with `mem_req_write` = 1. The entry is removed on an edge where `mem_req_ready` is 1. Entries leave in the order they came in.
- R5: A read whose address matches no entry shows on the memory port from the cycle after it is taken, with `mem_req_write` = 0 and the read address. Queued writes are held back until memory accepts that read.
- R6: For a read sent to memory, the cycle after `mem_rd_valid` is 1, `rd_resp_valid` is 1 for one cycle, `rd_resp_fwd` is 0, and `rd_resp_data` equals the `mem_rd_data` that was present.
- R7: A read whose address matches queued entries gets `rd_resp_valid` = 1, `rd_resp_fwd` = 1, and the data of the newest matching entry in the cycle after it is taken. No memory read is issued for it.
- R8: `rd_ready` is 0 from the edge that takes a read until the edge that ends its response cycle. The response cycle itself has `rd_ready` = 0.
- R9: On an edge where one write enters and one entry drains, `fill_level` does not change.
- R10: If an evicted line is queued and a read to another address follows, memory receives the read first and the evicted line's write after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_valid | input | 1 | Write pair offered by the cache |
| wr_ready | output | 1 | Queue can take a write |
| wr_addr | input | AW (16) | Write address |
| wr_data | input | DW (32) | Write data |
| rd_valid | input | 1 | Read miss offered |
| rd_ready | output | 1 | A read can be taken |
| rd_addr | input | AW (16) | Read address |
| rd_resp_valid | output | 1 | Read result valid, one cycle |
| rd_resp_data | output | DW (32) | Read result |
| rd_resp_fwd | output | 1 | 1 when the result came from the queue |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 for a queued write, 0 for a read |
| mem_req_addr | output | AW (16) | Request address |
| mem_req_data | output | DW (32) | Write data (0 for reads) |
| mem_rd_valid | input | 1 | Memory returns read data |
| mem_rd_data | input | DW (32) | Returned read data |
| fill_level | output | $clog2(DEPTH+1) (3) | Number of queued writes |

## Verification
Each result has a fixed cycle. The fill count moves one edge after a write is taken or an entry drains. A miss shows on the memory port one edge after it is taken. A forwarded result appears one edge after the read is taken, and a memory result one edge after `mem_rd_valid`. The bench drives inputs just after a rising edge and reads outputs in the same cycle, so each check looks at the cycle named above. A monitor logs memory handshakes at the falling edge, and the order of reads and writes is checked against that log.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;

    // Read-side sequencing
    typedef enum logic [1:0] {
        RD_IDLE  = 2'd0,
        RD_ISSUE = 2'd1,
        RD_WAIT  = 2'd2,
        RD_RESP  = 2'd3
    } rd_state_e;

    // Source of a read result
    typedef enum logic {
        SRC_MEMORY = 1'b0,
        SRC_QUEUE  = 1'b1
    } resp_src_e;

    function automatic int unsigned ptr_bits(input int unsigned depth);
        return (depth < 2) ? 1 : $clog2(depth);
    endfunction

endpackage

// File: rtl/wbuf_fifo.sv
module wbuf_fifo
    import wbuf_pkg::*;
#(
    parameter int unsigned DEPTH = 4,
    parameter int unsigned AW    = 16,
    parameter int unsigned DW    = 32,
    localparam int unsigned PW   = ptr_bits(DEPTH),
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          push,
    input  logic [AW-1:0]                 push_addr,
    input  logic [DW-1:0]                 push_data,
    input  logic                          pop,
    output logic [CW-1:0]                 count,
    output logic                          full,
    output logic                          empty,
    output logic [DEPTH-1:0][AW-1:0]      ord_addr,
    output logic [DEPTH-1:0][DW-1:0]      ord_data,
    output logic [DEPTH-1:0]              ord_vld
);
    logic [AW-1:0] slot_addr [DEPTH];
    logic [DW-1:0] slot_data [DEPTH];
    logic [PW-1:0] head, tail;

    assign full  = (count == CW'(DEPTH));
    assign empty = (count == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            head  <= '0;
            tail  <= '0;
            count <= '0;
        end else begin
            if (push) tail <= tail + PW'(1);
            if (pop)  head <= head + PW'(1);
            count <= count + CW'(push) - CW'(pop);
        end
    end

    always_ff @(posedge clk) begin
        if (push) begin
            slot_addr[tail] <= push_addr;
            slot_data[tail] <= push_data;
        end
    end

    // Present entries oldest first: position k is k places behind the head
    for (genvar k = 0; k < DEPTH; k++) begin : g_order
        logic [PW-1:0] idx;
        assign idx         = head + PW'(k);
        assign ord_addr[k] = slot_addr[idx];
        assign ord_data[k] = slot_data[idx];
        assign ord_vld[k]  = (CW'(k) < count);
    end

    // R3: occupancy never passes the depth
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));

    // R3: a write is only stored when a slot is free
    p_push_has_room_r3: assert property (@(posedge clk) disable iff (rst)
        push |-> (count < CW'(DEPTH)));

    // R4: draining needs an entry
    p_pop_nonempty_r4: assert property (@(posedge clk) disable iff (rst)
        pop |-> (count != '0));

    // R9: one push with one pop leaves the count alone
    p_push_pop_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (push && pop) |=> (count == $past(count)));

endmodule

// File: rtl/wbuf_match.sv
module wbuf_match #(
    parameter int unsigned DEPTH = 4,
    parameter int unsigned AW    = 16,
    parameter int unsigned DW    = 32
) (
    input  logic [DEPTH-1:0][AW-1:0] ord_addr,
    input  logic [DEPTH-1:0][DW-1:0] ord_data,
    input  logic [DEPTH-1:0]         ord_vld,
    input  logic [AW-1:0]            look_addr,
    output logic                     hit,
    output logic [DW-1:0]            hit_data
);
    // Scan oldest to newest; a later match overrides, so the newest wins
    always_comb begin
        hit      = 1'b0;
        hit_data = '0;
        for (int k = 0; k < DEPTH; k++) begin
            if (ord_vld[k] && (ord_addr[k] == look_addr)) begin
                hit      = 1'b1;
                hit_data = ord_data[k];
            end
        end
    end
endmodule

// File: rtl/wbuf_port_arb.sv
module wbuf_port_arb
    import wbuf_pkg::*;
#(
    parameter int unsigned AW = 16,
    parameter int unsigned DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rd_valid,
    input  logic [AW-1:0] rd_addr,
    output logic          rd_ready,
    input  logic          lk_hit,
    input  logic [DW-1:0] lk_data,
    output logic          rd_resp_valid,
    output logic [DW-1:0] rd_resp_data,
    output logic          rd_resp_fwd,
    input  logic          head_valid,
    input  logic [AW-1:0] head_addr,
    input  logic [DW-1:0] head_data,
    output logic          pop,
    output logic          mem_req_valid,
    input  logic          mem_req_ready,
    output logic          mem_req_write,
    output logic [AW-1:0] mem_req_addr,
    output logic [DW-1:0] mem_req_data,
    input  logic          mem_rd_valid,
    input  logic [DW-1:0] mem_rd_data
);
    rd_state_e     state;
    logic [AW-1:0] miss_addr;
    logic [DW-1:0] resp_data_q;
    resp_src_e     resp_src_q;
    logic          rd_take, rd_issue;

    assign rd_ready      = (state == RD_IDLE);
    assign rd_take       = rd_valid && rd_ready;
    assign rd_issue      = (state == RD_ISSUE);

    // One port: a waiting read always outranks the queue head
    assign mem_req_valid = rd_issue || head_valid;
    assign mem_req_write = !rd_issue;
    assign mem_req_addr  = rd_issue ? miss_addr : head_addr;
    assign mem_req_data  = rd_issue ? '0 : head_data;
    assign pop           = head_valid && !rd_issue && mem_req_ready;

    assign rd_resp_valid = (state == RD_RESP);
    assign rd_resp_data  = resp_data_q;
    assign rd_resp_fwd   = (resp_src_q == SRC_QUEUE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= RD_IDLE;
            miss_addr   <= '0;
            resp_data_q <= '0;
            resp_src_q  <= SRC_MEMORY;
        end else begin
            unique case (state)
                RD_IDLE: if (rd_take) begin
                    if (lk_hit) begin
                        resp_data_q <= lk_data;
                        resp_src_q  <= SRC_QUEUE;
                        state       <= RD_RESP;
                    end else begin
                        miss_addr   <= rd_addr;
                        state       <= RD_ISSUE;
                    end
                end
                RD_ISSUE: if (mem_req_ready) state <= RD_WAIT;
                RD_WAIT: if (mem_rd_valid) begin
                    resp_data_q <= mem_rd_data;
                    resp_src_q  <= SRC_MEMORY;
                    state       <= RD_RESP;
                end
                RD_RESP: state <= RD_IDLE;
                default: state <= RD_IDLE;
            endcase
        end
    end

    // R5: a miss goes to the port in the next cycle, as a read of its address
    p_miss_first_r5: assert property (@(posedge clk) disable iff (rst)
        (rd_take && !lk_hit) |=>
            (mem_req_valid && !mem_req_write && mem_req_addr == $past(rd_addr)));

    // R7: a hit answers from the queue in the next cycle
    p_hit_forward_r7: assert property (@(posedge clk) disable iff (rst)
        (rd_take && lk_hit) |=>
            (rd_resp_valid && rd_resp_fwd && rd_resp_data == $past(lk_data)));

    // R6: returned memory data is passed on in the next cycle
    p_mem_return_r6: assert property (@(posedge clk) disable iff (rst)
        (state == RD_WAIT && mem_rd_valid) |=>
            (rd_resp_valid && !rd_resp_fwd && rd_resp_data == $past(mem_rd_data)));

    // R8: no new read is taken while a result is being returned
    p_single_read_r8: assert property (@(posedge clk) disable iff (rst)
        rd_resp_valid |-> !rd_ready);

    // R6: a result lasts exactly one cycle
    p_resp_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        rd_resp_valid |=> !rd_resp_valid);

endmodule

// File: rtl/wbuf_bypass.sv
module wbuf_bypass
    import wbuf_pkg::*;
#(
    parameter int unsigned DEPTH = 4,
    parameter int unsigned AW    = 16,
    parameter int unsigned DW    = 32,
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_valid,
    output logic          wr_ready,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_valid,
    output logic          rd_ready,
    input  logic [AW-1:0] rd_addr,
    output logic          rd_resp_valid,
    output logic [DW-1:0] rd_resp_data,
    output logic          rd_resp_fwd,
    output logic          mem_req_valid,
    input  logic          mem_req_ready,
    output logic          mem_req_write,
    output logic [AW-1:0] mem_req_addr,
    output logic [DW-1:0] mem_req_data,
    input  logic          mem_rd_valid,
    input  logic [DW-1:0] mem_rd_data,
    output logic [CW-1:0] fill_level
);
    logic                     push, pop, full, empty, lk_hit;
    logic [DW-1:0]            lk_data;
    logic [DEPTH-1:0][AW-1:0] ord_addr;
    logic [DEPTH-1:0][DW-1:0] ord_data;
    logic [DEPTH-1:0]         ord_vld;

    assign wr_ready = !full;
    assign push     = wr_valid && wr_ready;

    wbuf_fifo #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_fifo (
        .clk(clk), .rst(rst),
        .push(push), .push_addr(wr_addr), .push_data(wr_data),
        .pop(pop), .count(fill_level), .full(full), .empty(empty),
        .ord_addr(ord_addr), .ord_data(ord_data), .ord_vld(ord_vld)
    );

    wbuf_match #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_match (
        .ord_addr(ord_addr), .ord_data(ord_data), .ord_vld(ord_vld),
        .look_addr(rd_addr), .hit(lk_hit), .hit_data(lk_data)
    );

    wbuf_port_arb #(.AW(AW), .DW(DW)) u_arb (
        .clk(clk), .rst(rst),
        .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_ready(rd_ready),
        .lk_hit(lk_hit), .lk_data(lk_data),
        .rd_resp_valid(rd_resp_valid), .rd_resp_data(rd_resp_data),
        .rd_resp_fwd(rd_resp_fwd),
        .head_valid(!empty), .head_addr(ord_addr[0]), .head_data(ord_data[0]),
        .pop(pop),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
        .mem_req_data(mem_req_data),
        .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data)
    );

    // R4: a write request on the port always has a queued entry behind it
    p_write_needs_entry_r4: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && mem_req_write) |-> (fill_level != '0));

    // R2: the count moves by at most one per edge
    p_count_step_r2: assert property (@(posedge clk) disable iff (rst)
        (fill_level == $past(fill_level)) ||
        (fill_level == $past(fill_level) + CW'(1)) ||
        (fill_level == $past(fill_level) - CW'(1)));

endmodule

// File: tb/test_wbuf_bypass.sv
module test_wbuf_bypass;
    localparam int AW = 16;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_valid = 1'b0, rd_valid = 1'b0;
    logic          mem_req_ready = 1'b0, mem_rd_valid = 1'b0;
    logic [AW-1:0] wr_addr = '0, rd_addr = '0;
    logic [DW-1:0] wr_data = '0, mem_rd_data = '0;
    logic          wr_ready, rd_ready, rd_resp_valid, rd_resp_fwd;
    logic          mem_req_valid, mem_req_write;
    logic [AW-1:0] mem_req_addr;
    logic [DW-1:0] rd_resp_data, mem_req_data;
    logic [2:0]    fill_level;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic          log_we   [64];
    logic [AW-1:0] log_addr [64];
    logic [DW-1:0] log_data [64];
    int            log_n = 0;

    always #5 clk = ~clk;

    wbuf_bypass i_wbuf_bypass (
        .clk(clk), .rst(rst),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
        .rd_resp_valid(rd_resp_valid), .rd_resp_data(rd_resp_data), .rd_resp_fwd(rd_resp_fwd),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr), .mem_req_data(mem_req_data),
        .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data), .fill_level(fill_level)
    );

    // Memory-side handshake log, sampled mid-cycle
    always @(negedge clk) begin
        if (!rst && mem_req_valid && mem_req_ready && log_n < 64) begin
            log_we[log_n]   <= mem_req_write;
            log_addr[log_n] <= mem_req_addr;
            log_data[log_n] <= mem_req_data;
            log_n           <= log_n + 1;
        end
    end

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_log(input int idx, input bit we, input logic [AW-1:0] a,
                           input logic [DW-1:0] d, input string req);
        chk(log_we[idx] == we, req, longint'(log_we[idx]), longint'(we));
        chk(log_addr[idx] == a, req, longint'(log_addr[idx]), longint'(a));
        if (we) chk(log_data[idx] == d, req, longint'(log_data[idx]), longint'(d));
    endtask

    task automatic push_one(input logic [AW-1:0] a, input logic [DW-1:0] d);
        wr_valid = 1'b1; wr_addr = a; wr_data = d;
        tick();
        wr_valid = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) tick();
        rst = 1'b0;
        chk(fill_level == 0, "R1 count", fill_level, 0);
        chk(wr_ready && rd_ready, "R1 ready", {wr_ready, rd_ready}, 2'b11);
        chk(!mem_req_valid && !rd_resp_valid, "R1 idle", {mem_req_valid, rd_resp_valid}, 0);
    endtask

    task automatic t_fill_and_drain();
        int base;
        mem_req_ready = 1'b0;
        for (int i = 0; i < 4; i++) begin
            push_one(AW'(16'h0100 + i * 4), DW'(32'hA000_0000 + i));
            chk(fill_level == 3'(i + 1), "R2 count", fill_level, i + 1);
        end
        chk(!wr_ready, "R3 full ready", wr_ready, 0);
        wr_valid = 1'b1; wr_addr = 16'h01F0; wr_data = 32'hDEAD_BEEF;
        tick(); tick();
        wr_valid = 1'b0;
        chk(fill_level == 4, "R3 dropped write", fill_level, 4);
        chk(mem_req_valid && mem_req_write && mem_req_addr == 16'h0100,
            "R4 head shown", mem_req_addr, 16'h0100);
        base = log_n;
        mem_req_ready = 1'b1;
        repeat (4) tick();
        mem_req_ready = 1'b0;
        chk(fill_level == 0, "R4 drained", fill_level, 0);
        chk(log_n - base == 4, "R3 no extra drain", log_n - base, 4);
        for (int i = 0; i < 4; i++)
            chk_log(base + i, 1'b1, AW'(16'h0100 + i * 4), DW'(32'hA000_0000 + i), "R4 order");
    endtask

    task automatic t_read_hit();
        int base;
        mem_req_ready = 1'b0;
        push_one(16'h0010, 32'h1111_0001);
        push_one(16'h0020, 32'h2222_0002);
        push_one(16'h0010, 32'h3333_0003);
        chk(rd_ready, "R8 ready before", rd_ready, 1);
        rd_valid = 1'b1; rd_addr = 16'h0010;
        tick();
        rd_valid = 1'b0;
        chk(rd_resp_valid && rd_resp_fwd, "R7 fwd valid", {rd_resp_valid, rd_resp_fwd}, 2'b11);
        chk(rd_resp_data == 32'h3333_0003, "R7 newest data", rd_resp_data, 32'h3333_0003);
        chk(!rd_ready, "R8 busy in resp", rd_ready, 0);
        chk(mem_req_write, "R7 no mem read", mem_req_write, 1);
        tick();
        chk(!rd_resp_valid && rd_ready, "R8 back to idle", {rd_resp_valid, rd_ready}, 2'b01);
        rd_valid = 1'b1; rd_addr = 16'h0020;
        tick();
        rd_valid = 1'b0;
        chk(rd_resp_valid && rd_resp_data == 32'h2222_0002, "R7 single match",
            rd_resp_data, 32'h2222_0002);
        tick();
        base = log_n;
        mem_req_ready = 1'b1;
        repeat (3) tick();
        mem_req_ready = 1'b0;
        chk(log_n - base == 3, "R7 only writes", log_n - base, 3);
        chk_log(base, 1'b1, 16'h0010, 32'h1111_0001, "R4 order");
        chk_log(base + 2, 1'b1, 16'h0010, 32'h3333_0003, "R4 order");
    endtask

    task automatic t_miss_victim();
        int base;
        mem_req_ready = 1'b0;
        push_one(16'h0040, 32'h7777_0040);   // evicted line
        push_one(16'h0044, 32'h7777_0044);
        base = log_n;
        rd_valid = 1'b1; rd_addr = 16'h0080;
        tick();
        rd_valid = 1'b0;
        chk(mem_req_valid && !mem_req_write, "R5 read on port",
            {mem_req_valid, mem_req_write}, 2'b10);
        chk(mem_req_addr == 16'h0080, "R5 read addr", mem_req_addr, 16'h0080);
        mem_req_ready = 1'b1;
        tick();
        chk(!rd_ready && !rd_resp_valid, "R8 busy in wait", {rd_ready, rd_resp_valid}, 0);
        mem_rd_valid = 1'b1; mem_rd_data = 32'hCAFE_0080;
        tick();
        mem_rd_valid = 1'b0;
        chk(rd_resp_valid && !rd_resp_fwd, "R6 mem resp", {rd_resp_valid, rd_resp_fwd}, 2'b10);
        chk(rd_resp_data == 32'hCAFE_0080, "R6 mem data", rd_resp_data, 32'hCAFE_0080);
        tick();
        mem_req_ready = 1'b0;
        chk(fill_level == 0, "R10 drained", fill_level, 0);
        chk(log_n - base == 3, "R10 count", log_n - base, 3);
        chk_log(base, 1'b0, 16'h0080, '0, "R10 read first");
        chk_log(base + 1, 1'b1, 16'h0040, 32'h7777_0040, "R10 victim after");
        chk_log(base + 2, 1'b1, 16'h0044, 32'h7777_0044, "R10 victim after");
    endtask

    task automatic t_push_pop();
        int base;
        mem_req_ready = 1'b0;
        base = log_n;
        push_one(16'h0300, 32'h0000_0300);
        chk(fill_level == 1, "R2 count", fill_level, 1);
        mem_req_ready = 1'b1;
        push_one(16'h0304, 32'h0000_0304);
        chk(fill_level == 1, "R9 hold", fill_level, 1);
        tick();
        mem_req_ready = 1'b0;
        chk(fill_level == 0, "R9 drained", fill_level, 0);
        chk_log(base, 1'b1, 16'h0300, 32'h0000_0300, "R9 order");
        chk_log(base + 1, 1'b1, 16'h0304, 32'h0000_0304, "R9 order");
    endtask

    initial begin
        t_reset();
        t_fill_and_drain();
        t_read_hit();
        t_miss_victim();
        t_push_pop();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #1000000;
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule